// File: doc/BRIEF.md
# Two-Half Command Port Decoder

This block sits behind the control port of a video memory controller. The host CPU can only write 16 bits at a time, so an access command reaches the block as two consecutive writes. The block puts them together into a 6-bit command code and a 17-bit address. An internal flag records whether a first half is waiting for its second. The block decodes the command code into a target memory and a direction, and raises a one-cycle DMA start request when a completed command asks for one.

A control write whose top two bits form a fixed tag, and that arrives while no half is waiting, is not a command at all. It loads one entry of a 24-entry byte register file. The block also answers data-port read requests. It acknowledges a request only when the current command selects a readable target. With any other command the request is never acknowledged.

Top module: `cmd_port_decoder`

## Requirements
- R1: A control write made while no half is waiting, whose bits 15:14 are not binary 10, is a first half. It loads code bits 1:0 from word bits 15:14 and address bits 13:0 from word bits 13:0. Code bits 5:2 and address bits 16:14 keep their earlier values, and the next control write is taken as a second half.
- R2: A control write made while a first half is waiting is a second half. It loads code bits 5:2 from word bits 7:4 and address bits 16:14 from word bits 2:0. Word bits 15:8 and bit 3 are ignored, and the write after it is a first half again.
- R3: A control write made while no half is waiting, with bits 15:14 equal to binary 10, writes word bits 7:0 into register number word bits 12:8. It leaves the command code and address unchanged and leaves no half waiting. The register file output places register n at bits 8n+7:8n, and no other event changes a register.
- R4: A register write to an index of 24 or higher changes no register.
- R5: A control-port read discards a waiting half. When a control read and a control write fall in the same cycle, the write is decoded with the state from before the read, and after that cycle no half is waiting.
- R6: The low four code bits select the target. 0000 is a video-RAM read and 0001 a video-RAM write. 1000 is a colour-RAM read and 0011 a colour-RAM write. 0100 is a scroll-RAM read and 0101 a scroll-RAM write. 1100 is a byte-wide video-RAM read. All other codes select no target. The target output is encoded as none=0, video RAM=1, colour RAM=2, scroll RAM=3 and byte video RAM=4. The write output equals code bit 0.
- R7: DMA request is high for exactly the one cycle after the clock edge that takes a second half with word bit 7 set, and only if bit 4 of register 1 is set. The target does not matter. The copy output equals code bit 4.
- R8: Read acknowledge is high only while a data read request is present and code bits 3:0 are 0000, 1000, 0100 or 1100. With any other code it stays low for as long as the request is held.
- R9: After reset every register is zero, the code and address are zero, no half is waiting and DMA request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control-port write strobe, one word per cycle |
| ctrl_rd | input | 1 | Control-port read strobe |
| wdata | input | 16 | Control-port write word |
| data_rd | input | 1 | Data-port read request, held until acknowledged |
| rd_ack | output | 1 | Data-port read acknowledge |
| cmd_code | output | 6 | Assembled command code |
| cmd_addr | output | 17 | Assembled command address |
| cmd_target | output | 3 | Decoded target memory |
| cmd_write | output | 1 | Command direction, 1 = write |
| dma_req | output | 1 | One-cycle DMA start request |
| dma_copy | output | 1 | DMA copy select from the command code |
| reg_file | output | 192 | Register file contents, register n at bits 8n+7:8n |

## Verification
A control read and a control write can land in the same cycle. One discards the waiting half and the other may set it or use it. The bench forces this once in a directed test: a first half goes in together with a read, and the word after it must then be taken as a register write. It also happens many times in the randomized phase. In every one of those cycles the behavioural model decodes the write against the state from before the read and then clears the waiting flag. The model's code, address and register contents are compared with the design on every clock.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    localparam int WORD_W      = 16;
    localparam int CODE_W      = 6;
    localparam int ADDR_W      = 17;
    localparam int LO_ADDR_W   = 14;
    localparam int NUM_REGS    = 24;
    localparam int REG_W       = 8;
    localparam int REG_IDX_W   = 5;
    localparam int DMA_EN_REG  = 1;
    localparam int DMA_EN_BIT  = 4;
    localparam logic [1:0] REG_TAG = 2'b10;

    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_VRAM  = 3'd1,
        TGT_CRAM  = 3'd2,
        TGT_VSRAM = 3'd3,
        TGT_VRAM8 = 3'd4
    } tgt_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic tgt_e decode_target(input logic [3:0] sel);
        case (sel)
            4'b0000, 4'b0001: decode_target = TGT_VRAM;
            4'b0011, 4'b1000: decode_target = TGT_CRAM;
            4'b0100, 4'b0101: decode_target = TGT_VSRAM;
            4'b1100:          decode_target = TGT_VRAM8;
            default:          decode_target = TGT_NONE;
        endcase
    endfunction

    function automatic logic is_readable(input logic [3:0] sel);
        case (sel)
            4'b0000, 4'b1000, 4'b0100, 4'b1100: is_readable = 1'b1;
            default:                            is_readable = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cpd_half_assembler.sv
module cpd_half_assembler
    import cpd_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int IW = REG_IDX_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  logic          ctrl_rd,
    input  logic [W-1:0]  wdata,
    output cmd_t          cmd,
    output logic          pending,
    output logic          reg_we,
    output logic [IW-1:0] reg_idx,
    output logic [RW-1:0] reg_val,
    output logic          second_take,
    output logic          second_start
);

    cmd_t cmd_q;
    logic pending_q;
    logic is_reg, is_first, is_second;

    always_comb begin
        is_reg    = ctrl_wr && !pending_q && (wdata[15:14] == REG_TAG);
        is_first  = ctrl_wr && !pending_q && !is_reg;
        is_second = ctrl_wr && pending_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            pending_q <= 1'b0;
        end else begin
            if (is_first) begin
                cmd_q.code[1:0]           <= wdata[15:14];
                cmd_q.addr[LO_ADDR_W-1:0] <= wdata[LO_ADDR_W-1:0];
            end
            if (is_second) begin
                cmd_q.code[CODE_W-1:2]           <= wdata[7:4];
                cmd_q.addr[ADDR_W-1:LO_ADDR_W]   <= wdata[2:0];
            end
            if (ctrl_rd)
                pending_q <= 1'b0;
            else if (is_first)
                pending_q <= 1'b1;
            else if (is_second || is_reg)
                pending_q <= 1'b0;
        end
    end

    assign cmd          = cmd_q;
    assign pending      = pending_q;
    assign reg_we       = is_reg;
    assign reg_idx      = wdata[8+IW-1:8];
    assign reg_val      = wdata[RW-1:0];
    assign second_take  = is_second;
    assign second_start = wdata[7];

endmodule

// File: rtl/cpd_regfile.sv
module cpd_regfile
    import cpd_pkg::*;
#(
    parameter int N  = NUM_REGS,
    parameter int IW = REG_IDX_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [RW-1:0] val,
    output logic [N*RW-1:0] flat
);

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [RW-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst)
                r_q <= '0;
            else if (we && (idx == IW'(g)))
                r_q <= val;
        end
        assign flat[g*RW +: RW] = r_q;
    end

endmodule

// File: rtl/cpd_target_decode.sv
module cpd_target_decode
    import cpd_pkg::*;
(
    input  logic [3:0] sel,
    output tgt_e       target,
    output logic       is_write,
    output logic       can_read
);

    always_comb begin
        target   = decode_target(sel);
        is_write = sel[0];
        can_read = is_readable(sel);
    end

endmodule

// File: rtl/cmd_port_decoder.sv
module cmd_port_decoder
    import cpd_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CODE_W,
    parameter int AW = ADDR_W,
    parameter int N  = NUM_REGS,
    parameter int RW = REG_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ctrl_wr,
    input  logic           ctrl_rd,
    input  logic [W-1:0]   wdata,
    input  logic           data_rd,
    output logic           rd_ack,
    output logic [CW-1:0]  cmd_code,
    output logic [AW-1:0]  cmd_addr,
    output logic [2:0]     cmd_target,
    output logic           cmd_write,
    output logic           dma_req,
    output logic           dma_copy,
    output logic [N*RW-1:0] reg_file
);

    localparam int EN_POS = DMA_EN_REG * RW + DMA_EN_BIT;

    cmd_t                 cmd;
    logic                 pending_q;
    logic                 reg_we;
    logic [REG_IDX_W-1:0] reg_idx;
    logic [RW-1:0]        reg_val;
    logic                 second_take, second_start;
    tgt_e                 target;
    logic                 is_write, can_read;
    logic                 dma_q;

    cpd_half_assembler u_asm (
        .clk          (clk),
        .rst          (rst),
        .ctrl_wr      (ctrl_wr),
        .ctrl_rd      (ctrl_rd),
        .wdata        (wdata),
        .cmd          (cmd),
        .pending      (pending_q),
        .reg_we       (reg_we),
        .reg_idx      (reg_idx),
        .reg_val      (reg_val),
        .second_take  (second_take),
        .second_start (second_start)
    );

    cpd_regfile u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (reg_we),
        .idx  (reg_idx),
        .val  (reg_val),
        .flat (reg_file)
    );

    cpd_target_decode u_dec (
        .sel      (cmd.code[3:0]),
        .target   (target),
        .is_write (is_write),
        .can_read (can_read)
    );

    always_ff @(posedge clk) begin
        if (rst)
            dma_q <= 1'b0;
        else
            dma_q <= second_take && second_start && reg_file[EN_POS];
    end

    assign cmd_code   = cmd.code;
    assign cmd_addr   = cmd.addr;
    assign cmd_target = target;
    assign cmd_write  = is_write;
    assign dma_req    = dma_q;
    assign dma_copy   = cmd.code[4];
    assign rd_ack     = data_rd && can_read;

endmodule

// File: rtl/cmd_port_decoder_chk.sv
module cmd_port_decoder_chk #(
    parameter int W  = 16,
    parameter int NR = 192
) (
    input logic          clk,
    input logic          rst,
    input logic          ctrl_wr,
    input logic          ctrl_rd,
    input logic [W-1:0]  wdata,
    input logic          data_rd,
    input logic          rd_ack,
    input logic          dma_req,
    input logic          pending_q,
    input logic [NR-1:0] reg_file
);

    assert_first_half_R1: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !pending_q && wdata[15:14] != 2'b10 && !ctrl_rd) |=> pending_q);

    assert_second_half_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && pending_q) |=> !pending_q);

    assert_regwr_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !pending_q && wdata[15:14] == 2'b10) |=> !pending_q);

    assert_regs_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(reg_file));

    assert_high_index_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !pending_q && wdata[15:14] == 2'b10 && wdata[12:8] >= 5'd24)
        |=> $stable(reg_file));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd |=> !pending_q);

    assert_dma_cause_R7: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> $past(ctrl_wr && pending_q && wdata[7]));

    assert_dma_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !(ctrl_wr && pending_q)) |=> !dma_req);

    assert_ack_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> data_rd);

endmodule

bind cmd_port_decoder cmd_port_decoder_chk #(.W(W), .NR(N*RW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ctrl_rd   (ctrl_rd),
    .wdata     (wdata),
    .data_rd   (data_rd),
    .rd_ack    (rd_ack),
    .dma_req   (dma_req),
    .pending_q (pending_q),
    .reg_file  (reg_file)
);

// File: tb/cmd_port_decoder_tb.sv
module cmd_port_decoder_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctrl_wr = 1'b0;
    logic         ctrl_rd = 1'b0;
    logic [15:0]  wdata = '0;
    logic         data_rd = 1'b0;
    logic         rd_ack;
    logic [5:0]   cmd_code;
    logic [16:0]  cmd_addr;
    logic [2:0]   cmd_target;
    logic         cmd_write;
    logic         dma_req;
    logic         dma_copy;
    logic [191:0] reg_file;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference state
    int  m_code, m_addr, m_pend, m_dma;
    int  m_regs[24];

    always #10 clk = ~clk;

    cmd_port_decoder u_dut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
        .wdata(wdata), .data_rd(data_rd), .rd_ack(rd_ack),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_target(cmd_target),
        .cmd_write(cmd_write), .dma_req(dma_req), .dma_copy(dma_copy),
        .reg_file(reg_file)
    );

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int exp_target(input int c);
        case (c & 15)
            0, 1:  return 1;
            3, 8:  return 2;
            4, 5:  return 3;
            12:    return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_readable(input int c);
        int s = c & 15;
        return (s == 0) || (s == 8) || (s == 4) || (s == 12);
    endfunction

    function automatic logic [191:0] model_flat();
        logic [191:0] v;
        for (int i = 0; i < 24; i++) v[i*8 +: 8] = m_regs[i][7:0];
        return v;
    endfunction

    // reference model, updated each clock, compared after outputs settle
    always @(posedge clk) begin
        if (rst) begin
            m_code = 0; m_addr = 0; m_pend = 0; m_dma = 0;
            for (int i = 0; i < 24; i++) m_regs[i] = 0;
        end else begin
            m_dma = 0;
            if (ctrl_wr) begin
                if (m_pend == 0) begin
                    if (wdata[15:14] == 2'b10) begin
                        if (wdata[12:8] < 24) m_regs[wdata[12:8]] = wdata[7:0];
                    end else begin
                        m_code = (m_code & 'h3C) | wdata[15:14];
                        m_addr = (m_addr & 'h1C000) | wdata[13:0];
                        m_pend = 1;
                    end
                end else begin
                    m_code = (m_code & 3) | (wdata[7:4] << 2);
                    m_addr = (m_addr & 'h3FFF) | (wdata[2:0] << 14);
                    m_pend = 0;
                    if (wdata[7] && m_regs[1][4]) m_dma = 1;
                end
            end
            if (ctrl_rd) m_pend = 0;
        end
        #5;
        if (!done) begin
            chk("R1/R2 code", cmd_code, m_code);
            chk("R1/R2 addr", cmd_addr, m_addr);
            chk("R6 target", cmd_target, exp_target(m_code));
            chk("R6 write", cmd_write, m_code & 1);
            chk("R7 dma_req", dma_req, m_dma);
            chk("R7 dma_copy", dma_copy, (m_code >> 4) & 1);
            chk("R3/R4 regs", reg_file, model_flat());
            chk("R8 rd_ack", rd_ack, data_rd && exp_readable(m_code));
        end
    end

    task automatic wr(input logic [15:0] w, input bit rd = 1'b0);
        @(negedge clk);
        ctrl_wr = 1'b1; wdata = w; ctrl_rd = rd;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_rd = 1'b0; wdata = $urandom;
    endtask

    task automatic rd_ctrl();
        @(negedge clk); ctrl_rd = 1'b1;
        @(negedge clk); ctrl_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 regs", reg_file, 0);
        chk("R9 code", cmd_code, 0);
        chk("R9 addr", cmd_addr, 0);
        chk("R9 dma", dma_req, 0);

        // R3: enable DMA through register 1
        wr(16'h8110);
        chk("R3 reg1", reg_file[15:8], 8'h10);

        // R1 R2 R6: colour-RAM write at address 0
        wr(16'hC000); wr(16'h0000);
        chk("R6 cram target", cmd_target, 2);
        chk("R6 cram write", cmd_write, 1);
        chk("R2 addr", cmd_addr, 0);

        // R7: DMA with scroll-RAM write, junk in ignored bits (R2)
        wr(16'h4ABC); wr(16'hFF9B);
        chk("R7 dma pulse", dma_req, 1);
        chk("R2 code", cmd_code, 6'h25);
        chk("R2 addr hi", cmd_addr, 17'h0CABC);
        chk("R6 vsram", cmd_target, 3);
        @(negedge clk);
        chk("R7 dma single", dma_req, 0);

        // R7 copy select, and no DMA when disabled
        wr(16'h4000); wr(16'h00C0);
        chk("R7 copy", dma_copy, 1);
        wr(16'h8100);
        wr(16'h4000); wr(16'h0080);
        chk("R7 dma disabled", dma_req, 0);

        // R4: out-of-range indices
        wr(16'h9855); wr(16'h9F77);
        chk("R4 regs unchanged", reg_file, {176'h0, 8'h00, 8'h00});

        // R5: control read drops a waiting half
        wr(16'h4000); rd_ctrl(); wr(16'h8F02);
        chk("R5 reg15", reg_file[127:120], 8'h02);

        // R5: read and first half in one cycle
        wr(16'h4123, 1'b1);
        chk("R5 addr low", cmd_addr[13:0], 14'h0123);
        wr(16'h8205);
        chk("R5 reg2", reg_file[23:16], 8'h05);

        // R8: dead read target 1001, then valid 0000
        wr(16'h4000); wr(16'h0020);
        @(negedge clk); data_rd = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk("R8 no ack", rd_ack, 0);
        end
        data_rd = 1'b0;
        wr(16'h0000); wr(16'h0000);
        @(negedge clk); data_rd = 1'b1; #1;
        chk("R8 ack", rd_ack, 1);
        @(negedge clk); data_rd = 1'b0;

        // randomized phase, model compares every clock
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            ctrl_wr = ($urandom % 3) == 0;
            ctrl_rd = ($urandom % 11) == 0;
            data_rd = $urandom % 2;
            wdata   = $urandom;
            if (($urandom % 4) == 0) wdata[15:14] = 2'b10;
            if (($urandom % 5) == 0) wdata[12:8] = 5'd1;
        end
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_rd = 1'b0; data_rd = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule